// File: doc/BRIEF.md
# Multi-Window Triggered Signal Capture Core

This block is an embedded logic-analyzer core. It records windows of on-chip probe samples into an internal memory. Probe inputs come in three groups. Data-only probes are stored but never compared. Trigger-only probes are compared but never stored. A third group is both stored and compared.

A sequential trigger of one or more stages starts each window. Each stage compares the compare-capable probes against a per-bit value, and a per-bit mask marks the don't-care bits. The stages must match in order before a window starts filling. An optional qualifier, checked on every enabled cycle, decides which samples are actually written. The memory is split evenly into a power-of-two number of back-to-back windows. After each window fills, the sequencer returns to its first stage for the next window.

A small write-only register port sets up the trigger and the qualifier, selects the stage and window counts, and arms the core. Status outputs show the phase, the stage being waited on and the window being filled. Once every window is full, the whole memory streams out over a valid/ready handshake.

Top module: `sigcap_core`

## Requirements
- R1: After synchronous active-low reset, `st_state` is 0 (idle), `cfg_err` is 0 and `rd_valid` is 0.
- R2: A stored word is `{probe_both, probe_data}`, with `probe_both` in the upper bits. `probe_trig` is never stored. `probe_data` never affects stage or qualifier matching.
- R3: The compared vector is `{probe_both, probe_trig}`. Stage s matches when every bit whose mask bit is 1 equals its value bit. Stage s value is written at address 0x10+2s and its mask at 0x11+2s. The stage count (1..MAX_STAGES) is written at 0x00. Stages are checked in order, only the current stage is checked, and at most one stage advances per enabled cycle. `st_stage` shows the stage being waited on.
- R4: When the last stage matches, storing starts with the sample of the next enabled cycle. Each window holds DEPTH / windows samples.
- R5: The qualifier value is written at 0x03 and its mask at 0x04, and matching works as in R3. While filling, a sample is stored only on an enabled cycle where the qualifier matches. A zero qualifier mask stores every enabled sample.
- R6: When a window fills, the core either returns to waiting on stage 0 with `st_window` incremented, or, after the last window, enters done (`st_state` = 3).
- R7: The window count is written at 0x01 and must be a power of two from 1 to DEPTH. The stage count must be from 1 to MAX_STAGES. An illegal value is dropped, the previous value is kept and `cfg_err` rises. Any accepted write to 0x00 or 0x01 clears `cfg_err`.
- R8: On a cycle with `clk_en` low, nothing is stored and the stage, window and state hold.
- R9: Writing any value to 0x02 arms the core from idle or done. While waiting or filling, all register writes, arm included, are ignored.
- R10: In done, `rd_valid` is 1 and DEPTH words come out in capture order: window 0 first, each window oldest first. `rd_data` holds while `rd_ready` is low, `rd_last` marks the final word, and after that word the core returns to idle.
- R11: `st_state` encodes 0 idle, 1 waiting on a trigger stage, 2 filling, 3 done. `st_window` is the index of the window being filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Sample enable; matching and storing advance only when high |
| probe_data | input | DATA_W | Data-only probes |
| probe_both | input | BOTH_W | Probes that are stored and compared |
| probe_trig | input | TRIG_W | Trigger-only probes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | REG_W | Register write value |
| rd_valid | output | 1 | Readout word available |
| rd_ready | input | 1 | Readout consumer accepts the word |
| rd_data | output | DATA_W+BOTH_W | Readout word |
| rd_last | output | 1 | Final word of the readout |
| st_state | output | 2 | Phase: idle, wait, fill, done |
| st_stage | output | STG_W | Trigger stage being waited on |
| st_window | output | log2(DEPTH) | Window being filled |
| cfg_err | output | 1 | Last stage/window count write was illegal |

## Verification
The assertions check several rules on every cycle. A low `clk_en` freezes the phase, stage and window while the core is armed. The stage index steps by at most one and the window index never goes backwards during a run. A rise of `cfg_err` always follows a register write. A stalled readout word holds, and the final accepted word returns the core to idle. Other behaviour can only be shown by the bench's scenarios, which sweep every legal window count against every stage count and run the qualifier both off and on. Those scenarios show the captured contents and their order, the exclusion of the trigger sample, the rejection of illegal counts and of writes during a run, and that data-only probes do not influence triggering.

// File: rtl/sigcap_pkg.sv
// Shared definitions for the signal capture core.
// Assumes: window counts handed to bit_index are powers of two.
package sigcap_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_WAIT = 2'd1,
        CAP_FILL = 2'd2,
        CAP_DONE = 2'd3
    } cap_state_e;

    // Position of the highest set bit; the base-2 log of a power of two.
    function automatic int unsigned bit_index(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/sigcap_cfg.sv
// Register file of the capture core: stage and window counts, per-stage
// value/mask pairs, qualifier value/mask and the arm strobe.
// Assumes: REG_W >= CMP_W, REG_W < 32, and 0x10+2*MAX_STAGES fits in 8 bits.
// All writes are dropped while busy is high.
module sigcap_cfg #(
    parameter int REG_W      = 16,
    parameter int CMP_W      = 8,
    parameter int MAX_STAGES = 4,
    parameter int DEPTH      = 64,
    parameter int STG_W      = 2,
    parameter int WLOG_W     = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                busy,
    input  logic                                wr_en,
    input  logic [7:0]                          wr_addr,
    input  logic [REG_W-1:0]                    wr_data,
    output logic                                arm,
    output logic [STG_W-1:0]                    last_stage,
    output logic [WLOG_W-1:0]                   win_log,
    output logic [MAX_STAGES-1:0][CMP_W-1:0]    stg_val,
    output logic [MAX_STAGES-1:0][CMP_W-1:0]    stg_msk,
    output logic [CMP_W-1:0]                    q_val,
    output logic [CMP_W-1:0]                    q_msk,
    output logic                                cfg_err
);
    import sigcap_pkg::*;

    localparam logic [REG_W:0] DEPTH_R = (REG_W+1)'(DEPTH);
    localparam logic [REG_W:0] MAXS_R  = (REG_W+1)'(MAX_STAGES);

    logic wr_ok;
    logic win_legal;
    logic stg_legal;

    assign wr_ok     = wr_en && !busy;
    assign arm       = wr_ok && (wr_addr == 8'h02);
    assign win_legal = (wr_data != '0) &&
                       ((wr_data & (wr_data - REG_W'(1))) == '0) &&
                       ({1'b0, wr_data} <= DEPTH_R);
    assign stg_legal = (wr_data != '0) && ({1'b0, wr_data} <= MAXS_R);

    // Count registers and the illegal-value flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_stage <= '0;
            win_log    <= '0;
            cfg_err    <= 1'b0;
        end else if (wr_ok && wr_addr == 8'h00) begin
            if (stg_legal) last_stage <= STG_W'(wr_data - REG_W'(1));
            cfg_err <= !stg_legal;
        end else if (wr_ok && wr_addr == 8'h01) begin
            if (win_legal) win_log <= WLOG_W'(bit_index(32'(wr_data)));
            cfg_err <= !win_legal;
        end
    end

    // Qualifier value and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_val <= '0;
            q_msk <= '0;
        end else if (wr_ok && wr_addr == 8'h03) begin
            q_val <= wr_data[CMP_W-1:0];
        end else if (wr_ok && wr_addr == 8'h04) begin
            q_msk <= wr_data[CMP_W-1:0];
        end
    end

    for (genvar s = 0; s < MAX_STAGES; s++) begin : g_stage
        logic [CMP_W-1:0] val_q;
        logic [CMP_W-1:0] msk_q;
        // Value and mask of one trigger stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
                msk_q <= '0;
            end else if (wr_ok && wr_addr == 8'(16 + 2*s)) begin
                val_q <= wr_data[CMP_W-1:0];
            end else if (wr_ok && wr_addr == 8'(17 + 2*s)) begin
                msk_q <= wr_data[CMP_W-1:0];
            end
        end
        assign stg_val[s] = val_q;
        assign stg_msk[s] = msk_q;
    end

endmodule

// File: rtl/sigcap_match.sv
// Masked comparators: one per trigger stage, plus the capture qualifier.
// A mask bit of 1 compares that bit, 0 ignores it. With QUAL_EN = 0 the
// qualifier is left out and every sample qualifies.
module sigcap_match #(
    parameter int CMP_W      = 8,
    parameter int MAX_STAGES = 4,
    parameter bit QUAL_EN    = 1'b1
) (
    input  logic [CMP_W-1:0]                    cmp,
    input  logic [MAX_STAGES-1:0][CMP_W-1:0]    stg_val,
    input  logic [MAX_STAGES-1:0][CMP_W-1:0]    stg_msk,
    input  logic [CMP_W-1:0]                    q_val,
    input  logic [CMP_W-1:0]                    q_msk,
    output logic [MAX_STAGES-1:0]               stg_hit,
    output logic                                q_hit
);
    for (genvar s = 0; s < MAX_STAGES; s++) begin : g_cmp
        assign stg_hit[s] = ((cmp ^ stg_val[s]) & stg_msk[s]) == '0;
    end

    if (QUAL_EN) begin : g_qual
        assign q_hit = ((cmp ^ q_val) & q_msk) == '0;
    end else begin : g_noqual
        logic unused_q;
        assign unused_q = ^{q_val, q_msk};
        assign q_hit    = 1'b1;
    end

endmodule

// File: rtl/sigcap_store.sv
// Sample memory: one synchronous write port, one asynchronous read port.
// Assumes: every location is written before it is read (not reset).
module sigcap_store #(
    parameter int MEM_W  = 12,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [MEM_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [MEM_W-1:0]  rdata
);
    logic [MEM_W-1:0] mem [DEPTH];

    // Write one sample.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sigcap_core.sv
// Multi-window triggered capture core. It sequences the trigger stages,
// fills each window with qualified samples, and streams the whole memory
// out once all windows are full.
// Assumes: DEPTH is a power of two >= 2; DATA_W, BOTH_W, TRIG_W >= 1;
// REG_W >= BOTH_W + TRIG_W.
module sigcap_core #(
    parameter int DATA_W     = 8,
    parameter int BOTH_W     = 4,
    parameter int TRIG_W     = 4,
    parameter int DEPTH      = 64,
    parameter int MAX_STAGES = 4,
    parameter bit QUAL_EN    = 1'b1,
    parameter int REG_W      = 16,
    localparam int MEM_W     = DATA_W + BOTH_W,
    localparam int CMP_W     = BOTH_W + TRIG_W,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int WLOG_W    = $clog2(ADDR_W + 1),
    localparam int STG_W     = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [DATA_W-1:0] probe_data,
    input  logic [BOTH_W-1:0] probe_both,
    input  logic [TRIG_W-1:0] probe_trig,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [MEM_W-1:0]  rd_data,
    output logic              rd_last,
    output logic [1:0]        st_state,
    output logic [STG_W-1:0]  st_stage,
    output logic [ADDR_W-1:0] st_window,
    output logic              cfg_err
);
    import sigcap_pkg::*;

    cap_state_e                         state_q;
    logic [STG_W-1:0]                   stage_q;
    logic [ADDR_W-1:0]                  win_q;
    logic [ADDR_W-1:0]                  fill_q;
    logic [ADDR_W-1:0]                  rd_ptr;
    logic                               busy;
    logic                               arm;
    logic [STG_W-1:0]                   last_stage;
    logic [WLOG_W-1:0]                  win_log;
    logic [MAX_STAGES-1:0][CMP_W-1:0]   stg_val;
    logic [MAX_STAGES-1:0][CMP_W-1:0]   stg_msk;
    logic [CMP_W-1:0]                   q_val;
    logic [CMP_W-1:0]                   q_msk;
    logic [MAX_STAGES-1:0]              stg_hit;
    logic                               q_hit;
    logic [ADDR_W:0]                    win_depth;
    logic                               fill_last;
    logic                               win_last;
    logic [WLOG_W-1:0]                  win_shift;
    logic [ADDR_W-1:0]                  waddr;
    logic                               store;

    assign busy = (state_q == CAP_WAIT) || (state_q == CAP_FILL);

    sigcap_cfg #(
        .REG_W(REG_W), .CMP_W(CMP_W), .MAX_STAGES(MAX_STAGES),
        .DEPTH(DEPTH), .STG_W(STG_W), .WLOG_W(WLOG_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .arm(arm), .last_stage(last_stage), .win_log(win_log),
        .stg_val(stg_val), .stg_msk(stg_msk),
        .q_val(q_val), .q_msk(q_msk), .cfg_err(cfg_err)
    );

    sigcap_match #(
        .CMP_W(CMP_W), .MAX_STAGES(MAX_STAGES), .QUAL_EN(QUAL_EN)
    ) u_match (
        .cmp({probe_both, probe_trig}),
        .stg_val(stg_val), .stg_msk(stg_msk),
        .q_val(q_val), .q_msk(q_msk),
        .stg_hit(stg_hit), .q_hit(q_hit)
    );

    // Window geometry derived from the configured window count.
    assign win_depth = (ADDR_W+1)'(DEPTH) >> win_log;
    assign fill_last = fill_q == ADDR_W'(win_depth - 1'b1);
    assign win_last  = win_q == ADDR_W'(((ADDR_W+1)'(1) << win_log) - 1'b1);
    assign win_shift = WLOG_W'(ADDR_W) - win_log;
    assign waddr     = ADDR_W'(win_q << win_shift) | fill_q;
    assign store     = (state_q == CAP_FILL) && clk_en && q_hit;

    sigcap_store #(
        .MEM_W(MEM_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
    ) u_store (
        .clk(clk), .we(store), .waddr(waddr),
        .wdata({probe_both, probe_data}),
        .raddr(rd_ptr), .rdata(rd_data)
    );

    // Capture sequencer: arm, stage walk, window fill, readout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            stage_q <= '0;
            win_q   <= '0;
            fill_q  <= '0;
            rd_ptr  <= '0;
        end else begin
            case (state_q)
                CAP_IDLE, CAP_DONE: begin
                    if (arm) begin
                        state_q <= CAP_WAIT;
                        stage_q <= '0;
                        win_q   <= '0;
                        fill_q  <= '0;
                        rd_ptr  <= '0;
                    end else if (state_q == CAP_DONE && rd_ready) begin
                        if (rd_last) state_q <= CAP_IDLE;
                        rd_ptr <= rd_ptr + 1'b1;
                    end
                end
                CAP_WAIT: begin
                    if (clk_en && stg_hit[stage_q]) begin
                        if (stage_q == last_stage) begin
                            state_q <= CAP_FILL;
                            stage_q <= '0;
                        end else begin
                            stage_q <= stage_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (store) begin
                        fill_q <= fill_last ? '0 : fill_q + 1'b1;
                        if (fill_last) begin
                            if (win_last) begin
                                state_q <= CAP_DONE;
                            end else begin
                                win_q   <= win_q + 1'b1;
                                state_q <= CAP_WAIT;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign rd_valid  = (state_q == CAP_DONE);
    assign rd_last   = rd_valid && (rd_ptr == '1);
    assign st_state  = state_q;
    assign st_stage  = stage_q;
    assign st_window = win_q;

endmodule

// File: rtl/sigcap_core_chk.sv
// Cycle-by-cycle properties of the capture core, bound to its ports.
module sigcap_core_chk #(
    parameter int MEM_W  = 12,
    parameter int STG_W  = 2,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              wr_en,
    input logic [7:0]        wr_addr,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [MEM_W-1:0]  rd_data,
    input logic              rd_last,
    input logic [1:0]        st_state,
    input logic [STG_W-1:0]  st_stage,
    input logic [ADDR_W-1:0] st_window,
    input logic              cfg_err
);
    logic armed;
    logic arm_wr;
    assign armed  = (st_state == 2'd1) || (st_state == 2'd2);
    assign arm_wr = wr_en && (wr_addr == 8'h02);

    AST_CE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !clk_en) |=> ($stable(st_state) && $stable(st_stage) && $stable(st_window))); // R8

    AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_state == 2'd1) |=> (st_stage == $past(st_stage) || st_stage == $past(st_stage) + 1'b1 || st_stage == '0)); // R3

    AST_WINDOW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> (st_window >= $past(st_window))); // R6

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(wr_en)); // R7

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !arm_wr) |=> (rd_valid && $stable(rd_data))); // R10

    AST_LAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && rd_last && !arm_wr) |=> (st_state == 2'd0)); // R10

endmodule

bind sigcap_core sigcap_core_chk #(
    .MEM_W(MEM_W), .STG_W(STG_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/sigcap_core_bench.sv
// Sweeps every legal window count against every stage count on a small
// build, with the expected memory image computed in the bench.
module sigcap_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int MAXS       = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic [3:0] probe_data = '0;
    logic [1:0] probe_both = '0;
    logic [1:0] probe_trig = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic       rd_valid;
    logic       rd_ready = 1'b0;
    logic [5:0] rd_data;
    logic       rd_last;
    logic [1:0] st_state;
    logic [1:0] st_stage;
    logic [3:0] st_window;
    logic       cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int sv [MAXS];
    int sm [MAXS];
    logic [5:0] exp_mem [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    sigcap_core #(
        .DATA_W(4), .BOTH_W(2), .TRIG_W(2), .DEPTH(DEPTH),
        .MAX_STAGES(MAXS), .QUAL_EN(1'b1), .REG_W(16)
    ) u_sigcap_core (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .probe_data(probe_data), .probe_both(probe_both), .probe_trig(probe_trig),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
        .st_state(st_state), .st_stage(st_stage), .st_window(st_window), .cfg_err(cfg_err)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        clk_en  = 1'b0;
        wr_en   = 1'b1;
        wr_addr = 8'(a);
        wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_cap(input int nst, input int nwin, input int qmode,
                           input int seed, input bit retain, input bit poke);
        int m_state, m_stage, m_win, m_fill, wd, k, qv, qm, dv;
        logic [3:0] cv;
        bit en;
        wd = DEPTH / nwin;
        qv = (qmode != 0) ? 1 : 0;
        qm = (qmode != 0) ? 1 : 0;
        wr(1, nwin);
        if (retain) begin
            wr(1, 3);
            chk(int'(cfg_err), 1, "R7 window count 3 rejected");
        end
        wr(0, nst);
        chk(int'(cfg_err), 0, "R7 accepted count write clears error");
        for (int s = 0; s < MAXS; s++) begin
            sv[s] = (s * 5 + nwin * 3) % 16;
            sm[s] = (s == 0) ? 12 : ((s == 1) ? 6 : 15);
            wr(16 + 2*s, sv[s]);
            wr(17 + 2*s, sm[s]);
        end
        wr(3, qv);
        wr(4, qm);
        wr(2, 0);
        m_state = 1; m_stage = 0; m_win = 0; m_fill = 0; k = 0;
        while (m_state != 3 && k < 4000) begin
            if (k < 6) chk(int'(st_state), m_state, "R2 data-only probes hold trigger off");
            else chk(int'(st_state), m_state, "R11 R8 phase");
            chk(int'(st_window), m_win, "R6 window index");
            if (m_state == 1) chk(int'(st_stage), m_stage, "R3 stage index");
            cv = (k < 6) ? (4'(sv[0]) ^ 4'hC) : 4'((k * 7 + 3) % 16);
            dv = (k * 11 + seed) % 16;
            en = (k % 5) != 4;
            probe_both = cv[3:2];
            probe_trig = cv[1:0];
            probe_data = 4'(dv);
            clk_en = en;
            wr_en = poke && (k >= 6) && (k <= 8);
            wr_addr = 8'(k - 6);
            wr_data = (k == 6) ? 16'd1 : 16'd3;
            if (en) begin
                if (m_state == 1) begin
                    if (((int'(cv) ^ sv[m_stage]) & sm[m_stage]) == 0) begin
                        if (m_stage == nst - 1) begin
                            m_state = 2;
                            m_stage = 0;
                        end else begin
                            m_stage++;
                        end
                    end
                end else if (((int'(cv) ^ qv) & qm) == 0) begin
                    exp_mem[m_win * wd + m_fill] = {cv[3:2], 4'(dv)};
                    m_fill++;
                    if (m_fill == wd) begin
                        m_fill = 0;
                        if (m_win == nwin - 1) m_state = 3;
                        else begin
                            m_win++;
                            m_state = 1;
                        end
                    end
                end
            end
            k++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        clk_en = 1'b0;
        chk(int'(st_state), 3, "R6 done after last window");
        chk(int'(st_window), nwin - 1, "R6 final window index");
        chk(int'(cfg_err), 0, "R9 writes during run ignored");
        for (int i = 0; i < DEPTH; i++) begin
            if (i % 3 == 1) begin
                rd_ready = 1'b0;
                chk(int'(rd_valid), 1, "R10 valid during readout");
                @(negedge clk);
                chk(int'(rd_data), int'(exp_mem[i]), "R10 stalled word held");
            end
            rd_ready = 1'b1;
            if (retain) chk(int'(rd_data), int'(exp_mem[i]), "R7 old window count kept");
            else if (qmode != 0) chk(int'(rd_data), int'(exp_mem[i]), "R5 qualified word");
            else chk(int'(rd_data), int'(exp_mem[i]), "R4 R2 captured word");
            chk(int'(rd_last), (i == DEPTH - 1) ? 1 : 0, "R10 last flag");
            @(negedge clk);
        end
        rd_ready = 1'b0;
        chk(int'(st_state), 0, "R10 idle after readout");
        chk(int'(rd_valid), 0, "R10 valid drops after readout");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(int'(st_state), 0, "R1 idle after reset");
        chk(int'(cfg_err), 0, "R1 no error after reset");
        chk(int'(rd_valid), 0, "R1 no readout after reset");

        wr(1, 3);  chk(int'(cfg_err), 1, "R7 window count 3");
        wr(1, 2);  chk(int'(cfg_err), 0, "R7 window count 2 accepted");
        wr(1, 32); chk(int'(cfg_err), 1, "R7 window count above depth");
        wr(1, 0);  chk(int'(cfg_err), 1, "R7 window count zero");
        wr(0, 0);  chk(int'(cfg_err), 1, "R7 stage count zero");
        wr(0, 4);  chk(int'(cfg_err), 1, "R7 stage count above max");
        wr(0, 2);  chk(int'(cfg_err), 0, "R7 stage count accepted");

        run_cap(2, 2, 0, 5, 1'b1, 1'b0);
        run_cap(3, 4, 1, 9, 1'b0, 1'b1);
        for (int w = 0; w < 5; w++) begin
            for (int s = 1; s <= MAXS; s++) begin
                run_cap(s, 1 << w, (w + s) % 2, w * 3 + s, 1'b0, 1'b0);
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule